// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block exchanges one byte at a time over a three-wire synchronous serial link: a transfer clock, a serial output and a serial input. Software sets a mode register, then writes a byte into the data register; that write arms an eight-pulse exchange. On each falling transfer-clock edge the next outgoing bit appears on the serial output. On each rising edge the incoming bit is sampled and the data register shifts by one place. When the eighth rising edge has been taken, a sticky interrupt flag is raised. Reading the data register returns the byte shifted in.

The transfer clock is either generated inside the block or supplied from outside. An internal clock is a 50% duty square wave with a period of 4, 16, 32 or 64 system clocks. It idles high, and it stops high after the eighth pulse, at which point the serial output is released to high impedance. An external clock is passed through a two-stage synchroniser, and its edges are detected in the system clock domain. The system clock must be at least four times faster than the external clock. In external mode, shifting continues on every further external pulse after the flag is raised. The serial input can also be taken from the block's own output, which gives a loopback.

The processor side is a plain strobe interface: a write strobe with a register select and a data byte, a flag-clear strobe, and a read-data bus. It has no back-pressure. Every strobe takes effect in the cycle it is asserted.

Top module: `sio_shift_port`

## Requirements
- R1: After reset, irq_flag is 0, sclk_o is 1, sclk_oe and sout_oe are 0, and rd_data is 0x00.
- R2: A data write (wr_en=1, wr_sel=1) loads the byte, sets the pulse counter to 7 and forces the internal clock high. With the internal clock, the first falling edge of sclk_o comes D/2 system clocks after the write edge, where D is the selected divide ratio.
- R3: Mode bits [1:0] select D: 00 gives 4, 01 gives 16, 10 gives 32 and 11 gives 64. The internal clock is high for D/2 cycles and low for D/2 cycles.
- R4: sout_o changes only on falling transfer-clock edges, and the serial input is sampled on rising edges. With mode bit 5 = 0 the order is LSB first: data bit 0 goes out first, and the first bit received ends up in rd_data bit 0.
- R5: With mode bit 5 = 1 the order is MSB first: data bit 7 goes out first, and the first bit received ends up in rd_data bit 7.
- R6: With the internal clock (mode bit 2 = 1), the eighth rising edge comes 8*D cycles after the write. At that edge irq_flag is set, and sclk_o then stays high with no further pulses.
- R7: With the internal clock and pins enabled, sout_oe is 1 while a transfer runs and 0 once it has completed.
- R8: Mode bit 3 enables the serial pins. When it is 0, sclk_oe and sout_oe are both 0, but the transfer still runs and still sets irq_flag. When it is 1, sclk_oe equals mode bit 2.
- R9: With mode bit 6 = 1, the sampled input is the block's own serial output instead of sin_i, so the byte read back equals the byte written.
- R10: With the external clock (mode bit 2 = 0), sclk_i is synchronised. irq_flag is set on the eighth external rising edge after a data write and not earlier. Further external pulses keep shifting. In this mode sout_oe follows mode bit 3.
- R11: irq_flag stays set until flag_clr is pulsed, and it is 0 in the cycle after the pulse.
- R12: rd_data always shows the data register, so after a completed exchange it holds the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 mode, 1 data |
| wr_data | input | 8 | Write data |
| flag_clr | input | 1 | Clears irq_flag |
| rd_data | output | 8 | Data register contents |
| irq_flag | output | 1 | Transfer-complete flag |
| sclk_i | input | 1 | Serial clock pin input (external mode) |
| sclk_o | output | 1 | Serial clock pin drive value |
| sclk_oe | output | 1 | Serial clock pin output enable |
| sout_o | output | 1 | Serial data output value |
| sout_oe | output | 1 | Serial data output enable |
| sin_i | input | 1 | Serial data input |

## Verification
The bench times the first falling edge and the flag for several divide ratios. A divider that is off by one, or that starts low, moves those cycle counts. It recovers the transmitted and received bytes in both bit orders and in loopback. A reversed shift or a wrong sampling edge therefore shows up as a mirrored or shifted byte. In external mode it checks that the flag is still clear after seven pulses and set after eight, and that eight more pulses replace the received byte. A design that stopped shifting, or that raised the flag early, fails those checks.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // Mode register layout
  typedef struct packed {
    logic       spare7;
    logic       loop_in;    // bit6: sample own output
    logic       msb_first;  // bit5: bit order
    logic       spare4;
    logic       pin_en;     // bit3: drive serial pins
    logic       int_clk;    // bit2: 1 internal clock
    logic [1:0] div_sel;    // bits1:0: divide select
  } sio_mode_t;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int HALF0 = 2,
  parameter int HALF1 = 8,
  parameter int HALF2 = 16,
  parameter int HALF3 = 32,
  parameter int PRE_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       sclk,
  output logic       fall,
  output logic       rise
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] half_m1;
  logic             tick;

  always_comb begin
    case (div_sel)
      2'd0:    half_m1 = PRE_W'(HALF0 - 1);
      2'd1:    half_m1 = PRE_W'(HALF1 - 1);
      2'd2:    half_m1 = PRE_W'(HALF2 - 1);
      default: half_m1 = PRE_W'(HALF3 - 1);
    endcase
  end

  assign tick = run && (pre == half_m1);
  assign fall = tick && sclk;
  assign rise = tick && !sclk;

  always_ff @(posedge clk) begin
    if (!rst_n || start || !run) begin
      pre  <= '0;
      sclk <= 1'b1;
    end else if (tick) begin
      pre  <= '0;
      sclk <= ~sclk;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // The clock is high again after every rising edge the divider makes
  assert_rise_leaves_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !start) |=> sclk);
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= 3'b111;
    else        sh <= {sh[1:0], pin};
  end

  assign rise = sh[1] && !sh[2];
  assign fall = !sh[1] && sh[2];
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rise,
  input  logic              fall,
  input  logic              msb_first,
  input  logic              ser_in,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] sreg,
  output logic              sout,
  output logic              active,
  output logic              irq
);
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last = rise && active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg   <= '0;
      sout   <= 1'b0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      sreg   <= load_data;
      cnt    <= CNT_W'(DATA_W - 1);
      active <= 1'b1;
    end else begin
      if (fall) sout <= msb_first ? sreg[DATA_W-1] : sreg[0];
      if (rise) begin
        sreg <= msb_first ? {sreg[DATA_W-2:0], ser_in} : {ser_in, sreg[DATA_W-1:1]};
        if (active) begin
          if (cnt == '0) active <= 1'b0;
          else           cnt    <= cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        irq <= 1'b0;
    else if (last)     irq <= 1'b1;
    else if (flag_clr) irq <= 1'b0;
  end

  assert_load_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (active && cnt == CNT_W'(DATA_W - 1)));
  assert_flag_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !load) |=> irq);
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(flag_clr));
  assert_sout_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sout) |-> $past(fall));
endmodule

// File: rtl/sio_shift_port.sv
module sio_shift_port #(
  parameter int DATA_W = 8,
  parameter int HALF0  = 2,
  parameter int HALF1  = 8,
  parameter int HALF2  = 16,
  parameter int HALF3  = 32,
  localparam int PRE_W = $clog2(HALF3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_flag,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              sout_o,
  output logic              sout_oe,
  input  logic              sin_i
);
  import sio_pkg::*;

  sio_mode_t mode;
  logic load, active, ser_in;
  logic rise_i, fall_i, rise_e, fall_e, rise_m, fall_m;

  always_ff @(posedge clk) begin
    if (!rst_n)                mode <= '0;
    else if (wr_en && !wr_sel) mode <= sio_mode_t'(wr_data[7:0]);
  end

  assign load = wr_en && wr_sel;

  sio_clkgen #(.HALF0(HALF0), .HALF1(HALF1), .HALF2(HALF2), .HALF3(HALF3),
               .PRE_W(PRE_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .start(load && mode.int_clk),
    .run(active && mode.int_clk), .div_sel(mode.div_sel),
    .sclk(sclk_o), .fall(fall_i), .rise(rise_i));

  sio_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin(sclk_i), .rise(rise_e), .fall(fall_e));

  assign rise_m = mode.int_clk ? rise_i : rise_e;
  assign fall_m = mode.int_clk ? fall_i : fall_e;
  assign ser_in = mode.loop_in ? sout_o : sin_i;

  sio_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(wr_data),
    .rise(rise_m), .fall(fall_m), .msb_first(mode.msb_first),
    .ser_in(ser_in), .flag_clr(flag_clr), .sreg(rd_data),
    .sout(sout_o), .active(active), .irq(irq_flag));

  assign sclk_oe = mode.pin_en && mode.int_clk;
  assign sout_oe = mode.pin_en && (!mode.int_clk || active);

  // Internal clock idles high whenever no transfer is running
  assert_idle_clock_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.int_clk && !active) |-> sclk_o);
  // Output released one cycle after an internal transfer ends
  assert_release_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.int_clk && $fell(active) && !load) |-> !sout_oe);
endmodule

// File: tb/tb_sio_shift_port.sv
module tb_sio_shift_port;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, wr_sel = 0, flag_clr = 0, sclk_i = 1, sin_i = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       irq_flag, sclk_o, sclk_oe, sout_o, sout_oe;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sio_shift_port dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .flag_clr(flag_clr), .rd_data(rd_data), .irq_flag(irq_flag),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sout_o(sout_o),
    .sout_oe(sout_oe), .sin_i(sin_i));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic [7:0] rev8(input [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic wr(input bit sel, input [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk); wr_en = 0;
  endtask

  task automatic clr_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    check(irq_flag == 0, "R11 flag clear", irq_flag, 0);
  endtask

  task automatic t_reset();
    check(irq_flag == 0, "R1 irq", irq_flag, 0);
    check(sclk_o == 1, "R1 sclk_o", sclk_o, 1);
    check(sclk_oe == 0 && sout_oe == 0, "R1 oe", {sclk_oe, sout_oe}, 0);
    check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
  endtask

  // Internal-clock exchange: checks timing, both bytes, stop and release
  task automatic run_internal(input [7:0] mode, input [7:0] tx, input [7:0] pat,
                              input [7:0] exp_rx, input int d, input bit msb, input string tag);
    int first_low = -1, irq_at = -1, nrise = 0, nfall = 0;
    logic prev = 1;
    logic [7:0] cap = 0;
    wr(0, mode);
    wr(1, tx);
    for (int k = 1; k <= 12 * d; k++) begin
      @(negedge clk);
      if (k == 1) check(sout_oe == 1, {"R7 oe busy ", tag}, sout_oe, 1);
      if (!sclk_o && prev) begin
        if (first_low < 0) first_low = k;
        if (nfall < 8) sin_i = pat[nfall];
        nfall++;
      end
      if (sclk_o && !prev) begin
        if (nrise < 8) cap[nrise] = sout_o;
        nrise++;
      end
      if (irq_flag && irq_at < 0) irq_at = k;
      prev = sclk_o;
    end
    check(first_low == d / 2, {"R2 R3 first fall ", tag}, first_low, d / 2);
    check(irq_at == 8 * d, {"R6 flag time ", tag}, irq_at, 8 * d);
    check(nrise == 8, {"R6 pulse count ", tag}, nrise, 8);
    check(sclk_o == 1, {"R6 stops high ", tag}, sclk_o, 1);
    check((msb ? rev8(cap) : cap) == tx, {msb ? "R5" : "R4", " tx bits ", tag},
          msb ? rev8(cap) : cap, tx);
    check(rd_data == exp_rx, {msb ? "R5" : "R4", " R12 rx byte ", tag}, rd_data, exp_rx);
    check(sout_oe == 0, {"R7 released ", tag}, sout_oe, 0);
    check(sclk_oe == 1, {"R8 sclk_oe ", tag}, sclk_oe, 1);
    clr_flag();
  endtask

  task automatic t_pin_disable();
    wr(0, 8'h04);
    wr(1, 8'h77);
    repeat (5) @(negedge clk);
    check(sclk_oe == 0 && sout_oe == 0, "R8 pins off", {sclk_oe, sout_oe}, 0);
    repeat (40) @(negedge clk);
    check(irq_flag == 1, "R8 transfer still runs", irq_flag, 1);
    repeat (3) @(negedge clk);
    check(irq_flag == 1, "R11 flag holds", irq_flag, 1);
    clr_flag();
  endtask

  task automatic ext_pulse(input bit b, output bit s);
    @(negedge clk); sclk_i = 0; sin_i = b;
    repeat (8) @(negedge clk);
    s = sout_o;
    sclk_i = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_external();
    logic [7:0] pat = 8'h5A, pat2 = 8'hC3, cap = 0;
    bit s;
    wr(0, 8'h08);
    check(sclk_oe == 0 && sout_oe == 1, "R10 R8 ext oe", {sclk_oe, sout_oe}, 1);
    wr(1, 8'h96);
    for (int i = 0; i < 8; i++) begin
      ext_pulse(pat[i], s);
      cap[i] = s;
      if (i == 6) check(irq_flag == 0, "R10 no flag after 7", irq_flag, 0);
    end
    check(irq_flag == 1, "R10 flag after 8", irq_flag, 1);
    check(cap == 8'h96, "R10 R4 ext tx", cap, 8'h96);
    check(rd_data == pat, "R10 R12 ext rx", rd_data, pat);
    for (int i = 0; i < 8; i++) ext_pulse(pat2[i], s);
    check(rd_data == pat2, "R10 keeps shifting", rd_data, pat2);
    check(irq_flag == 1, "R11 flag sticky", irq_flag, 1);
    clr_flag();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_internal(8'h0C, 8'hA5, 8'h3B, 8'h3B, 4, 0, "div4 lsb");
    run_internal(8'h0D, 8'h81, 8'hE4, 8'hE4, 16, 0, "div16 lsb");
    run_internal(8'h2E, 8'h1F, 8'h6D, rev8(8'h6D), 32, 1, "div32 msb");
    run_internal(8'h2F, 8'hC8, 8'h92, rev8(8'h92), 64, 1, "div64 msb");
    sin_i = 1;
    run_internal(8'h4C, 8'h3C, 8'hFF, 8'h3C, 4, 0, "R9 loopback");
    t_pin_disable();
    t_external();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule